// File: doc/BRIEF.md
# Power and Clock Domain Sleep Controller

This block gates the clock and local reset of peripheral modules, one module per power domain, under control of a simple 32-bit register bus. Software first writes the state it wants for a module (software-reset-disable, sync reset, disable or enable) together with a local-reset level. That write changes no output. The request takes effect only when software sets the domain's bit in a shared go register. That bit starts a timed transition of a fixed number of clock cycles. While the transition runs, the domain's busy bit can be polled.

When the transition ends, the module status register shows the new state, the local-reset level and a clock-running flag. The module's clock-enable and reset outputs follow the status. A domain that is powered off ignores module state changes. Software must set the domain's power-on request bit before issuing a go. The domain is then reported on (domain status 1) when that transition ends.

Each domain runs a two-state sequencer. IDLE moves to BUSY on a go (the *start* transition). BUSY stays in BUSY while cycles remain (*hold*). BUSY returns to IDLE when the count expires (*complete*), and that is when status is committed.

Top module: `pwr_gate_ctrl`

## Requirements
- R1: After reset, every status register reads 0, the busy bits read 0, and all `mod_clk_en` and `mod_rst_n` outputs are 0.
- R2: Writing 1 to bit N of the go register (byte offset 0x120) while domain N is idle makes bit N of the busy register (offset 0x128) read 1 from the next cycle.
- R3: A busy bit stays 1 for exactly TRANS_CYCLES clock cycles after the go write, then reads 0.
- R4: A go bit written to a domain that is already busy is ignored: the running transition is neither restarted nor lengthened.
- R5: Go bits at positions N_DOM and above have no effect; busy bits at those positions always read 0.
- R6: The module control register (offset 0xA00 + 4·N) holds the state in bits 5:0, an active-low local reset in bit 8 and a force flag in bit 31; reading it returns those bits, and all other bits read 0.
- R7: The module control value is captured at the go write. Control writes made during a transition do not change its outcome.
- R8: When a transition completes on a powered domain, module status (offset 0x800 + 4·N) bits 5:0 equal the captured state and bit 8 equals the captured local-reset level.
- R9: Module status bit 12 and `mod_clk_en[N]` are 1 exactly when the committed state is 3 (enable) on a powered domain.
- R10: `mod_rst_n[N]` is 1 only when the committed state is 2 (disable) or 3 (enable), the committed bit 8 is 1, and the domain is on; states 0 and 1 hold the module in reset.
- R11: If domain status (offset 0x200 + 4·N, bits 4:0) is 0 and domain control (offset 0x300 + 4·N) bit 0 is 1 at the go write, domain status reads 1 after the transition.
- R12: A transition on an off domain without the power-on request completes normally (busy clears) but leaves module status and domain status unchanged.
- R13: Module status, `mod_clk_en` and `mod_rst_n` change only at the completion of a transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| mod_clk_en | output | N_DOM | Clock enable for each domain's module |
| mod_rst_n | output | N_DOM | Active-low reset for each domain's module |

## Verification
The checker holds on every cycle that a go to an idle domain raises busy, that each busy period lasts exactly TRANS_CYCLES cycles however many extra go bits arrive, that the outputs move only when busy falls, and that busy bits beyond the implemented domains stay 0. The bench scenarios show what the checker cannot: which state lands in status, handling of the captured control value versus late writes, the power-on requirement for an off domain, and the reset and clock-enable decoding. These are checked against a bench model through directed off-to-enable-to-disable steps and seeded random requests.

// File: rtl/pgc_pkg.sv
package pgc_pkg;

    localparam int OFF_GO     = 'h120;
    localparam int OFF_BUSY   = 'h128;
    localparam int OFF_PDSTAT = 'h200;
    localparam int OFF_PDCTL  = 'h300;
    localparam int OFF_MDSTAT = 'h800;
    localparam int OFF_MDCTL  = 'hA00;

    localparam int ST_W = 6;

    typedef enum logic [ST_W-1:0] {
        MS_SWRST_DIS = 6'd0,
        MS_SYNC_RST  = 6'd1,
        MS_DISABLE   = 6'd2,
        MS_ENABLE    = 6'd3
    } mod_state_e;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_BUSY = 1'b1
    } phase_e;

endpackage

// File: rtl/pgc_domain.sv
module pgc_domain
    import pgc_pkg::*;
#(
    parameter int TRANS_CYCLES = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ctl_we,
    input  logic [ST_W-1:0] ctl_state_in,
    input  logic            ctl_lrst_in,
    input  logic            ctl_force_in,
    input  logic            pdctl_we,
    input  logic            pdctl_next_in,
    input  logic            go,
    output logic [31:0]     ctl_rd,
    output logic [31:0]     pdctl_rd,
    output logic [31:0]     pdstat_rd,
    output logic [31:0]     mdstat_rd,
    output logic            busy,
    output logic            clk_en,
    output logic            rst_out_n
);

    localparam int CW = (TRANS_CYCLES > 1) ? $clog2(TRANS_CYCLES) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(TRANS_CYCLES - 1);

    phase_e          ph_q, ph_d;
    logic [CW-1:0]   cnt_q;
    logic [ST_W-1:0] req_state_q, pend_state_q, st_q;
    logic            req_lrst_q, req_force_q, pd_next_q;
    logic            pend_lrst_q, pend_pwr_q;
    logic            st_lrst_q, pd_on_q;
    logic            start, done;

    // sequencer state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q <= PH_IDLE;
        else        ph_q <= ph_d;
    end

    // start: IDLE->BUSY on go; hold: BUSY while count runs; complete: BUSY->IDLE
    always_comb begin
        ph_d = ph_q;
        unique case (ph_q)
            PH_IDLE: if (go) ph_d = PH_BUSY;
            PH_BUSY: if (cnt_q == CNT_LAST) ph_d = PH_IDLE;
            default: ph_d = PH_IDLE;
        endcase
    end

    assign start = (ph_q == PH_IDLE) && go;
    assign done  = (ph_q == PH_BUSY) && (cnt_q == CNT_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= '0;
        end else if (ph_q == PH_BUSY) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    // software-visible request registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_state_q <= '0;
            req_lrst_q  <= 1'b0;
            req_force_q <= 1'b0;
            pd_next_q   <= 1'b0;
        end else begin
            if (ctl_we) begin
                req_state_q <= ctl_state_in;
                req_lrst_q  <= ctl_lrst_in;
                req_force_q <= ctl_force_in;
            end
            if (pdctl_we) pd_next_q <= pdctl_next_in;
        end
    end

    // capture at go, commit at completion
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_state_q <= '0;
            pend_lrst_q  <= 1'b0;
            pend_pwr_q   <= 1'b0;
            st_q         <= '0;
            st_lrst_q    <= 1'b0;
            pd_on_q      <= 1'b0;
        end else begin
            if (start) begin
                pend_state_q <= req_state_q;
                pend_lrst_q  <= req_lrst_q;
                pend_pwr_q   <= pd_next_q;
            end
            if (done) begin
                if (pend_pwr_q) pd_on_q <= 1'b1;
                if (pd_on_q || pend_pwr_q) begin
                    st_q      <= pend_state_q;
                    st_lrst_q <= pend_lrst_q;
                end
            end
        end
    end

    // outputs
    always_comb begin
        busy      = (ph_q == PH_BUSY);
        clk_en    = pd_on_q && (st_q == MS_ENABLE);
        rst_out_n = pd_on_q && st_lrst_q &&
                    ((st_q == MS_DISABLE) || (st_q == MS_ENABLE));
        ctl_rd    = {req_force_q, 22'd0, req_lrst_q, 2'd0, req_state_q};
        pdctl_rd  = {31'd0, pd_next_q};
        pdstat_rd = {27'd0, 4'd0, pd_on_q};
        mdstat_rd = {19'd0, clk_en, 3'd0, st_lrst_q, 2'd0, st_q};
    end

endmodule

// File: rtl/pgc_rdmux.sv
module pgc_rdmux
    import pgc_pkg::*;
#(
    parameter int N_DOM  = 4,
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0]         addr,
    input  logic [N_DOM-1:0]          busy,
    input  logic [N_DOM-1:0][31:0]    ctl,
    input  logic [N_DOM-1:0][31:0]    pdctl,
    input  logic [N_DOM-1:0][31:0]    pdstat,
    input  logic [N_DOM-1:0][31:0]    mdstat,
    output logic [31:0]               rdata
);

    always_comb begin
        rdata = '0;
        if (int'(addr) == OFF_BUSY) rdata[N_DOM-1:0] = busy;
        for (int d = 0; d < N_DOM; d++) begin
            if (int'(addr) == OFF_MDCTL  + 4*d) rdata = ctl[d];
            if (int'(addr) == OFF_PDCTL  + 4*d) rdata = pdctl[d];
            if (int'(addr) == OFF_PDSTAT + 4*d) rdata = pdstat[d];
            if (int'(addr) == OFF_MDSTAT + 4*d) rdata = mdstat[d];
        end
    end

endmodule

// File: rtl/pwr_gate_ctrl.sv
module pwr_gate_ctrl
    import pgc_pkg::*;
#(
    parameter int N_DOM        = 4,
    parameter int TRANS_CYCLES = 8,
    parameter int ADDR_W       = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [N_DOM-1:0]  mod_clk_en,
    output logic [N_DOM-1:0]  mod_rst_n
);

    logic [N_DOM-1:0]       go_v, busy_v;
    logic [N_DOM-1:0][31:0] ctl_v, pdctl_v, pdstat_v, mdstat_v;
    logic                   unused_wbits;

    assign unused_wbits = ^bus_wdata;

    for (genvar d = 0; d < N_DOM; d++) begin : g_dom
        logic ctl_we, pdctl_we;

        assign ctl_we   = bus_wr && (int'(bus_addr) == OFF_MDCTL + 4*d);
        assign pdctl_we = bus_wr && (int'(bus_addr) == OFF_PDCTL + 4*d);
        assign go_v[d]  = bus_wr && (int'(bus_addr) == OFF_GO) && bus_wdata[d];

        pgc_domain #(.TRANS_CYCLES(TRANS_CYCLES)) u_dom (
            .clk           (clk),
            .rst_n         (rst_n),
            .ctl_we        (ctl_we),
            .ctl_state_in  (bus_wdata[ST_W-1:0]),
            .ctl_lrst_in   (bus_wdata[8]),
            .ctl_force_in  (bus_wdata[31]),
            .pdctl_we      (pdctl_we),
            .pdctl_next_in (bus_wdata[0]),
            .go            (go_v[d]),
            .ctl_rd        (ctl_v[d]),
            .pdctl_rd      (pdctl_v[d]),
            .pdstat_rd     (pdstat_v[d]),
            .mdstat_rd     (mdstat_v[d]),
            .busy          (busy_v[d]),
            .clk_en        (mod_clk_en[d]),
            .rst_out_n     (mod_rst_n[d])
        );
    end

    pgc_rdmux #(.N_DOM(N_DOM), .ADDR_W(ADDR_W)) u_rdmux (
        .addr   (bus_addr),
        .busy   (busy_v),
        .ctl    (ctl_v),
        .pdctl  (pdctl_v),
        .pdstat (pdstat_v),
        .mdstat (mdstat_v),
        .rdata  (bus_rdata)
    );

endmodule

// File: rtl/pgc_chk.sv
module pgc_chk
    import pgc_pkg::*;
#(
    parameter int N_DOM        = 4,
    parameter int TRANS_CYCLES = 8,
    parameter int ADDR_W       = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_DOM-1:0]  go,
    input logic [N_DOM-1:0]  busy,
    input logic [N_DOM-1:0]  clk_en,
    input logic [N_DOM-1:0]  mod_rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic [31:0]       rdata
);

    localparam int KW = $clog2(TRANS_CYCLES + 2) + 1;
    localparam logic [31:0] DOM_MASK = (N_DOM >= 32) ? 32'hFFFF_FFFF : ((32'd1 << N_DOM) - 32'd1);

    for (genvar d = 0; d < N_DOM; d++) begin : g_chk
        logic [KW-1:0] run_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       run_q <= '0;
            else if (busy[d]) run_q <= run_q + KW'(1);
            else              run_q <= '0;
        end

        p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (go[d] && !busy[d]) |=> busy[d]);

        // R3 and R4: busy length is fixed even if go repeats
        p_busy_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(busy[d]) |-> (run_q == KW'(TRANS_CYCLES)));

        p_busy_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
            busy[d] |-> (run_q < KW'(TRANS_CYCLES)));

        p_out_stable_r13: assert property (@(posedge clk) disable iff (!rst_n)
            !$fell(busy[d]) |-> ($stable(clk_en[d]) && $stable(mod_rst_n[d])));
    end

    p_ext_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(addr) == OFF_BUSY) |-> ((rdata & ~DOM_MASK) == 32'd0));

endmodule

bind pwr_gate_ctrl pgc_chk #(
    .N_DOM(N_DOM), .TRANS_CYCLES(TRANS_CYCLES), .ADDR_W(ADDR_W)
) u_pgc_chk (
    .clk(clk), .rst_n(rst_n), .go(go_v), .busy(busy_v),
    .clk_en(mod_clk_en), .mod_rst_n(mod_rst_n),
    .addr(bus_addr), .rdata(bus_rdata)
);

// File: tb/tb_pwr_gate_ctrl.sv
module tb_pwr_gate_ctrl;

    localparam int N  = 4;
    localparam int T  = 8;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [N-1:0]  mod_clk_en, mod_rst_n;

    int total = 0;
    int bad   = 0;

    // bench model
    logic [31:0] m_ctl  [N];
    logic        m_next [N];
    logic        m_on   [N];
    logic [5:0]  m_st   [N];
    logic        m_lrst [N];
    logic [31:0] c_ctl  [N];
    logic        c_pwr  [N];

    always #2.5 clk = ~clk;

    pwr_gate_ctrl #(.N_DOM(N), .TRANS_CYCLES(T), .ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .mod_clk_en(mod_clk_en), .mod_rst_n(mod_rst_n)
    );

    function automatic logic [31:0] exp_md(int d);
        logic ce = m_on[d] && (m_st[d] == 6'd3);
        return {19'd0, ce, 3'd0, m_lrst[d], 2'd0, m_st[d]};
    endfunction

    function automatic logic exp_ce(int d);
        return m_on[d] && (m_st[d] == 6'd3);
    endfunction

    function automatic logic exp_rn(int d);
        return m_on[d] && m_lrst[d] && ((m_st[d] == 6'd2) || (m_st[d] == 6'd3));
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(int a, logic [31:0] v);
        bus_addr = AW'(a); bus_wdata = v; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(int a, output logic [31:0] v);
        bus_addr = AW'(a);
        #1;
        v = bus_rdata;
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_ctl(int d, logic [31:0] v);
        wr('hA00 + 4*d, v);
        m_ctl[d] = v & 32'h8000_013F;
    endtask

    task automatic set_pd(int d, logic v);
        wr('h300 + 4*d, {31'd0, v});
        m_next[d] = v;
    endtask

    task automatic go(int d);
        c_ctl[d] = m_ctl[d];
        c_pwr[d] = m_next[d];
        wr('h120, 32'd1 << d);
    endtask

    task automatic commit(int d);
        logic was_on = m_on[d];
        if (c_pwr[d]) m_on[d] = 1'b1;
        if (was_on || c_pwr[d]) begin
            m_st[d]   = c_ctl[d][5:0];
            m_lrst[d] = c_ctl[d][8];
        end
    endtask

    task automatic wait_idle(int d, string req);
        logic [31:0] v;
        int k = 0;
        rd('h128, v);
        while (v[d] && k < 100) begin
            step(1); k++;
            rd('h128, v);
        end
        chk(req, {31'd0, v[d]}, 32'd0);
        commit(d);
    endtask

    task automatic check_dom(int d, string req);
        logic [31:0] v;
        rd('h800 + 4*d, v); chk(req, v, exp_md(d));
        rd('h200 + 4*d, v); chk(req, v, {31'd0, m_on[d]});
        chk(req, {31'd0, mod_clk_en[d]}, {31'd0, exp_ce(d)});
        chk(req, {31'd0, mod_rst_n[d]}, {31'd0, exp_rn(d)});
    endtask

    initial begin
        logic [31:0] v;
        for (int d = 0; d < N; d++) begin
            m_ctl[d] = '0; m_next[d] = 1'b0; m_on[d] = 1'b0;
            m_st[d] = '0; m_lrst[d] = 1'b0; c_ctl[d] = '0; c_pwr[d] = 1'b0;
        end
        void'($urandom(32'h5EED_0042));
        step(3);
        rst_n = 1'b1;
        step(1);

        // R1: reset state
        rd('h128, v); chk("R1 busy", v, 32'd0);
        chk("R1 clk_en", {28'd0, mod_clk_en}, 32'd0);
        chk("R1 rst_n", {28'd0, mod_rst_n}, 32'd0);
        for (int d = 0; d < N; d++) check_dom(d, "R1 status");

        // R12: off domain, no power-on request, enable requested
        set_ctl(1, 32'h0000_0103);
        go(1);
        wait_idle(1, "R12 busy clear");
        check_dom(1, "R12 unchanged");

        // R11, R2, R3, R4, R7: power on + enable, exact timing
        set_pd(1, 1'b1);
        go(1);
        rd('h128, v); chk("R2 busy set", {31'd0, v[1]}, 32'd1);
        wr('hA00 + 4, 32'h0000_0002);            // R7 late write, not captured
        m_ctl[1] = 32'h0000_0002;
        wr('h120, 32'd1 << 1);                    // R4 repeat go while busy
        step(T - 3);
        rd('h128, v); chk("R3 busy held", {31'd0, v[1]}, 32'd1);
        step(1);
        rd('h128, v); chk("R3 busy length", {31'd0, v[1]}, 32'd0);
        commit(1);
        check_dom(1, "R11 R8 R9 R7 on+enable");
        chk("R9 enable", {31'd0, mod_clk_en[1]}, 32'd1);

        // R10: disable with local reset asserted (captured value 0x002)
        go(1);
        wait_idle(1, "R10 busy clear");
        check_dom(1, "R10 disable lrst");
        chk("R10 in reset", {31'd0, mod_rst_n[1]}, 32'd0);

        // R10: disable with local reset released
        set_ctl(1, 32'h0000_0102);
        go(1);
        wait_idle(1, "R10 busy clear");
        check_dom(1, "R10 disable run");

        // R10: sync reset holds reset even with bit 8 set
        set_ctl(1, 32'h0000_0101);
        go(1);
        wait_idle(1, "R10 busy clear");
        check_dom(1, "R10 syncrst");

        // R5: go bits beyond implemented domains
        wr('h120, 32'hFFFF_FFFF << N);
        rd('h128, v); chk("R5 no busy", v, 32'd0);

        // R6: control readback mask
        set_ctl(2, 32'hFFFF_FFFF);
        rd('hA00 + 8, v); chk("R6 readback", v, 32'h8000_013F);

        // seeded random requests
        for (int it = 0; it < 40; it++) begin
            int d = int'($urandom_range(N - 1, 0));
            set_ctl(d, $urandom());
            rd('hA00 + 4*d, v); chk("R6 readback", v, m_ctl[d]);
            if ($urandom_range(3, 0) == 0) set_pd(d, 1'($urandom()));
            go(d);
            if ($urandom_range(1, 0) == 1) begin
                wr('hA00 + 4*d, $urandom());      // R7 late write
                m_ctl[d] = bus_wdata & 32'h8000_013F;
            end
            wait_idle(d, "R3 busy clear");
            check_dom(d, "R8 R9 R10 R11 R12 random");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule